// File: doc/BRIEF.md
# Dual-Channel GPIO with Change Interrupt

This block is a memory-mapped general-purpose I/O peripheral with one or two channels. Each channel is up to 32 bits wide and holds two registers. One sets the driven value. The other sets the direction of each pin. Pins are modelled as three separate vectors per channel (sampled input, driven value and output enable), so pad buffers stay outside the block. Software reaches the registers through a simple word-wide port with byte addresses. A read returns its data on the clock edge after the request.

Every input pin passes through a two-flop synchronizer. The synchronized value is then compared with the previous sample. The block reports changes per channel, not per pin. Any change on an input bit of a channel sets that channel's status bit. Software acknowledges pending bits by writing the status value back. One interrupt line combines the status bits, the per-channel enable bits and a single global gate. Comparison starts only once the synchronizer holds real pin samples, so levels that are present when reset is released do not raise events.

Top module: `gpio_chg_irq`

## Requirements
- R1: After reset every direction bit is 1 (all pins are inputs), so every output enable is 0. Every driven value is 0, the interrupt line is low, and the global enable, status and interrupt enable registers read 0. A direction register reads back with ones only in the channel's implemented bits.
- R2: A direction bit of 1 makes the pin an input and a 0 makes it an output. A pin's output enable is the inverse of its direction bit. The driven vector equals the data register and changes only when that data register is written.
- R3: Channel 1 data sits at byte address 0x000 and its direction at 0x004. A data read returns the synchronized pin for input bits and the driven value for output bits. Bits above the channel width read 0.
- R4: Channel 2 data and direction sit 0x8 higher than channel 1, at 0x008 and 0x00C. Writing them leaves channel 1 untouched.
- R5: The status register is at 0x120, with bit 0 for channel 1 and bit 1 for channel 2. A channel's bit is set when any input-direction bit of its synchronized value differs from the previous sample. Toggling an output-direction pin sets nothing. The bit sets on the third rising edge after the pin changes.
- R6: A write to 0x120 clears exactly the status bits that are 1 in the written value and leaves the others unchanged. A change event arriving in the same cycle wins over the clear.
- R7: The global enable register is at 0x11C. Only bit 31 is stored; other bits are ignored and read 0. The interrupt line is high exactly when bit 31 is set and some channel has both its status and its enable bit set.
- R8: The interrupt enable register is at 0x128. It uses the same channel bit assignment as status and stores only the channel bits.
- R9: Any other address, including a misaligned one, reads 0, and writes to it change nothing.
- R10: With the second channel disabled by parameter, addresses 0x008 and 0x00C read 0 and status bit 1 never sets.
- R11: Pin levels held steady across the release of reset raise no change event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ch1_pin_i | input | CH1_W | Channel 1 pin input |
| ch1_pin_o | output | CH1_W | Channel 1 driven value |
| ch1_pin_oe | output | CH1_W | Channel 1 output enable, 1 drives the pin |
| ch2_pin_i | input | CH2_W | Channel 2 pin input |
| ch2_pin_o | output | CH2_W | Channel 2 driven value |
| ch2_pin_oe | output | CH2_W | Channel 2 output enable, 1 drives the pin |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is the release of reset with pins already at a nonzero level. Only there does the synchronizer's reset value differ from the real pin, which could create a false change. A second, single-channel, 8-bit instance is therefore held with a fixed pattern on its pins from time zero. Its status is read before any pin moves. That instance also shows the absent second channel and the zeroed upper bits. Masking of output-direction pins is reached by first turning half a channel into outputs and then toggling the pin inputs under both halves.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned GATE_BIT = 31;

    localparam logic [15:0] OFS_DATA   = 16'h000;
    localparam logic [15:0] OFS_DIR    = 16'h004;
    localparam logic [15:0] CH_STRIDE  = 16'h008;
    localparam logic [15:0] OFS_GATE   = 16'h11C;
    localparam logic [15:0] OFS_STATUS = 16'h120;
    localparam logic [15:0] OFS_ENABLE = 16'h128;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_D1,
        SEL_T1,
        SEL_D2,
        SEL_T2,
        SEL_GATE,
        SEL_STATUS,
        SEL_ENABLE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [15:0] a, input logic dual);
        reg_sel_e s;
        s = SEL_NONE;
        if (a == OFS_DATA)                          s = SEL_D1;
        else if (a == OFS_DIR)                      s = SEL_T1;
        else if (dual && a == OFS_DATA + CH_STRIDE) s = SEL_D2;
        else if (dual && a == OFS_DIR + CH_STRIDE)  s = SEL_T2;
        else if (a == OFS_GATE)                     s = SEL_GATE;
        else if (a == OFS_STATUS)                   s = SEL_STATUS;
        else if (a == OFS_ENABLE)                   s = SEL_ENABLE;
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_channel.sv
module gpio_channel #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic         wr_data,
    input  logic         wr_dir,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] data_rd,
    output logic [W-1:0] dir_rd,
    output logic         change
);

    localparam int unsigned CNT_W = $clog2(STAGES + 2);
    localparam logic [CNT_W-1:0] ARM_LAST = CNT_W'(STAGES + 1);

    typedef struct packed {
        logic [W-1:0]     drive;
        logic [W-1:0]     dir;
        logic [W-1:0]     prev;
        logic [CNT_W-1:0] arm_cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [W-1:0] sync_w;
    logic         armed;

    gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (sync_w)
    );

    assign armed = (st_q.arm_cnt == ARM_LAST);

    always_comb begin
        st_d = st_q;
        if (wr_data) st_d.drive = wr_val;
        if (wr_dir)  st_d.dir   = wr_val;
        st_d.prev = sync_w;
        if (!armed) st_d.arm_cnt = st_q.arm_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.drive   <= '0;
            st_q.dir     <= '1;
            st_q.prev    <= '0;
            st_q.arm_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o   = st_q.drive;
    assign pin_oe  = ~st_q.dir;
    assign data_rd = (sync_w & st_q.dir) | (st_q.drive & ~st_q.dir);
    assign dir_rd  = st_q.dir;
    assign change  = armed && (|((sync_w ^ st_q.prev) & st_q.dir));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
    parameter int unsigned NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_gate,
    input  logic           wr_status,
    input  logic           wr_enable,
    input  logic           gate_val,
    input  logic [NCH-1:0] ch_val,
    input  logic [NCH-1:0] chg,
    output logic           gate,
    output logic [NCH-1:0] status,
    output logic [NCH-1:0] enable,
    output logic           irq
);

    typedef struct packed {
        logic           gate;
        logic [NCH-1:0] status;
        logic [NCH-1:0] enable;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_gate)   st_d.gate   = gate_val;
        if (wr_enable) st_d.enable = ch_val;
        if (wr_status) st_d.status = st_q.status & ~ch_val;
        st_d.status = st_d.status | chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate   = st_q.gate;
    assign status = st_q.status;
    assign enable = st_q.enable;
    assign irq    = st_q.gate && (|(st_q.status & st_q.enable));

endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
    import gpio_chg_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned CH1_W  = 32,
    parameter int unsigned CH2_W  = 32,
    parameter int unsigned DUAL   = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [CH1_W-1:0]  ch1_pin_i,
    output logic [CH1_W-1:0]  ch1_pin_o,
    output logic [CH1_W-1:0]  ch1_pin_oe,
    input  logic [CH2_W-1:0]  ch2_pin_i,
    output logic [CH2_W-1:0]  ch2_pin_o,
    output logic [CH2_W-1:0]  ch2_pin_oe,
    output logic              irq_o
);

    localparam int unsigned NCH = (DUAL != 0) ? 2 : 1;

    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    reg_sel_e           sel_w;
    logic [CH1_W-1:0]   ch1_data, ch1_dir;
    logic [CH2_W-1:0]   ch2_data, ch2_dir;
    logic               ch1_chg, ch2_chg;
    logic [NCH-1:0]     chg_w, status_w, enable_w;
    logic               gate_w;

    assign sel_w = decode_addr(16'(bus_addr), DUAL != 0);

    gpio_channel #(.W(CH1_W), .STAGES(STAGES)) u_ch1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ch1_pin_i),
        .wr_data(bus_wr && sel_w == SEL_D1),
        .wr_dir (bus_wr && sel_w == SEL_T1),
        .wr_val (bus_wdata[CH1_W-1:0]),
        .pin_o  (ch1_pin_o),
        .pin_oe (ch1_pin_oe),
        .data_rd(ch1_data),
        .dir_rd (ch1_dir),
        .change (ch1_chg)
    );

    generate
        if (DUAL != 0) begin : g_ch2
            gpio_channel #(.W(CH2_W), .STAGES(STAGES)) u_ch2 (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_i  (ch2_pin_i),
                .wr_data(bus_wr && sel_w == SEL_D2),
                .wr_dir (bus_wr && sel_w == SEL_T2),
                .wr_val (bus_wdata[CH2_W-1:0]),
                .pin_o  (ch2_pin_o),
                .pin_oe (ch2_pin_oe),
                .data_rd(ch2_data),
                .dir_rd (ch2_dir),
                .change (ch2_chg)
            );
            assign chg_w = {ch2_chg, ch1_chg};
        end else begin : g_no_ch2
            assign ch2_pin_o  = '0;
            assign ch2_pin_oe = '0;
            assign ch2_data   = '0;
            assign ch2_dir    = '0;
            assign ch2_chg    = 1'b0;
            assign chg_w      = ch1_chg;
        end
    endgenerate

    gpio_irq_ctrl #(.NCH(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_gate  (bus_wr && sel_w == SEL_GATE),
        .wr_status(bus_wr && sel_w == SEL_STATUS),
        .wr_enable(bus_wr && sel_w == SEL_ENABLE),
        .gate_val (bus_wdata[GATE_BIT]),
        .ch_val   (bus_wdata[NCH-1:0]),
        .chg      (chg_w),
        .gate     (gate_w),
        .status   (status_w),
        .enable   (enable_w),
        .irq      (irq_o)
    );

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            unique case (sel_w)
                SEL_D1:     st_d.rdata = REG_W'(ch1_data);
                SEL_T1:     st_d.rdata = REG_W'(ch1_dir);
                SEL_D2:     st_d.rdata = REG_W'(ch2_data);
                SEL_T2:     st_d.rdata = REG_W'(ch2_dir);
                SEL_GATE:   st_d.rdata = {gate_w, {(REG_W-1){1'b0}}};
                SEL_STATUS: st_d.rdata = REG_W'(status_w);
                SEL_ENABLE: st_d.rdata = REG_W'(enable_w);
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/gpio_chg_irq_chk.sv
module gpio_chg_irq_chk
    import gpio_chg_pkg::*;
#(
    parameter int unsigned NCH   = 2,
    parameter int unsigned CH1_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input reg_sel_e         sel,
    input logic [CH1_W-1:0] ch1_pin_o,
    input logic [CH1_W-1:0] ch1_pin_oe,
    input logic             gate,
    input logic [NCH-1:0]   status,
    input logic [NCH-1:0]   enable,
    input logic [NCH-1:0]   chg,
    input logic             irq_o
);

    logic clr0;
    assign clr0 = bus_wr && sel == SEL_STATUS && bus_wdata[0];

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (ch1_pin_oe == '0 && !irq_o)); // R1

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && sel == SEL_D1) |=> $stable(ch1_pin_o)); // R2

    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        chg[0] |=> status[0]); // R5

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && !chg[0]) |=> !status[0]); // R6

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !clr0) |=> status[0]); // R6

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gate); // R7

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(status & enable))); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |=> bus_rdata == '0); // R9

endmodule

bind gpio_chg_irq gpio_chg_irq_chk #(.NCH(NCH), .CH1_W(CH1_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sel       (sel_w),
    .ch1_pin_o (ch1_pin_o),
    .ch1_pin_oe(ch1_pin_oe),
    .gate      (gate_w),
    .status    (status_w),
    .enable    (enable_w),
    .chg       (chg_w),
    .irq_o     (irq_o)
);

// File: tb/tb_gpio_chg_irq.sv
module tb_gpio_chg_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;

    logic [31:0] d_rdata, s_rdata;
    logic [31:0] d_g1_i = '0, d_g2_i = '0;
    logic [31:0] d_g1_o, d_g1_oe, d_g2_o, d_g2_oe;
    logic        d_irq;

    logic [7:0]  s_g1_i = 8'hA5;
    logic [7:0]  s_g2_i = '0;
    logic [7:0]  s_g1_o, s_g1_oe, s_g2_o, s_g2_oe;
    logic        s_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] rd_d, rd_s;

    always #10 clk = ~clk;

    gpio_chg_irq dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(d_rdata),
        .ch1_pin_i(d_g1_i), .ch1_pin_o(d_g1_o), .ch1_pin_oe(d_g1_oe),
        .ch2_pin_i(d_g2_i), .ch2_pin_o(d_g2_o), .ch2_pin_oe(d_g2_oe),
        .irq_o(d_irq)
    );

    gpio_chg_irq #(.CH1_W(8), .CH2_W(8), .DUAL(0)) dut_single (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(s_rdata),
        .ch1_pin_i(s_g1_i), .ch1_pin_o(s_g1_o), .ch1_pin_oe(s_g1_oe),
        .ch2_pin_i(s_g2_i), .ch2_pin_o(s_g2_o), .ch2_pin_oe(s_g2_oe),
        .irq_o(s_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        rd_d = d_rdata;
        rd_s = s_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 oe1", d_g1_oe, 32'h0);
        chk("R1 oe2", d_g2_oe, 32'h0);
        chk("R1 out1", d_g1_o, 32'h0);
        chk("R1 irq", {31'b0, d_irq}, 32'h0);
        rd(9'h004); chk("R1 dir1", rd_d, 32'hFFFF_FFFF);
        chk("R1 single dir1 width", rd_s, 32'h0000_00FF);
        rd(9'h00C); chk("R1 dir2", rd_d, 32'hFFFF_FFFF);
        rd(9'h11C); chk("R1 gate", rd_d, 32'h0);
        rd(9'h128); chk("R1 enable", rd_d, 32'h0);
    endtask

    task automatic t_single();
        settle();
        s_g2_i = 8'hFF;
        settle();
        rd(9'h120);
        chk("R11 no event from level held at reset", rd_s, 32'h0);
        rd(9'h000); chk("R3 single upper bits zero", rd_s, 32'h0000_00A5);
        rd(9'h008); chk("R10 single ch2 data", rd_s, 32'h0);
        rd(9'h00C); chk("R10 single ch2 dir", rd_s, 32'h0);
        s_g1_i = 8'hA4;
        settle();
        rd(9'h120); chk("R5 single ch1 event", rd_s, 32'h1);
    endtask

    task automatic t_dir_out();
        wr(9'h004, 32'hFFFF_0000);
        wr(9'h000, 32'h1234_ABCD);
        chk("R2 oe1", d_g1_oe, 32'h0000_FFFF);
        chk("R2 out1", d_g1_o, 32'h1234_ABCD);
        d_g1_i = 32'hCAFE_5555;
        settle();
        rd(9'h000); chk("R3 mixed read", rd_d, 32'hCAFE_ABCD);
    endtask

    task automatic t_ch2();
        wr(9'h00C, 32'h0);
        wr(9'h008, 32'h5A5A_0F0F);
        chk("R4 oe2", d_g2_oe, 32'hFFFF_FFFF);
        chk("R4 out2", d_g2_o, 32'h5A5A_0F0F);
        chk("R4 ch1 untouched", d_g1_o, 32'h1234_ABCD);
        rd(9'h008); chk("R4 ch2 read", rd_d, 32'h5A5A_0F0F);
        wr(9'h00C, 32'hFFFF_FFFF);
        rd(9'h008); chk("R4 ch2 input read", rd_d, 32'h0);
    endtask

    task automatic t_status();
        wr(9'h120, 32'h3);
        rd(9'h120); chk("R6 cleared", rd_d, 32'h0);
        d_g2_i = d_g2_i ^ 32'h20;
        settle();
        rd(9'h120); chk("R5 ch2 bit1", rd_d, 32'h2);
        d_g1_i = d_g1_i ^ 32'h8;
        settle();
        rd(9'h120); chk("R5 output pin masked", rd_d, 32'h2);
        d_g1_i = d_g1_i ^ 32'h0010_0000;
        settle();
        rd(9'h120); chk("R5 ch1 bit0", rd_d, 32'h3);
        wr(9'h120, 32'h1);
        rd(9'h120); chk("R6 partial clear", rd_d, 32'h2);
        wr(9'h120, 32'h2);
        rd(9'h120); chk("R6 full clear", rd_d, 32'h0);
    endtask

    task automatic t_irq();
        wr(9'h128, 32'h1);
        rd(9'h128); chk("R8 enable read", rd_d, 32'h1);
        d_g1_i = d_g1_i ^ 32'h0001_0000;
        settle();
        chk("R7 no irq without gate", {31'b0, d_irq}, 32'h0);
        wr(9'h11C, 32'h7FFF_FFFF);
        chk("R7 low gate bits ignored", {31'b0, d_irq}, 32'h0);
        rd(9'h11C); chk("R7 gate read low bits", rd_d, 32'h0);
        wr(9'h11C, 32'h8000_0000);
        chk("R7 irq on", {31'b0, d_irq}, 32'h1);
        rd(9'h11C); chk("R7 gate read", rd_d, 32'h8000_0000);
        wr(9'h120, 32'h1);
        chk("R7 irq off after ack", {31'b0, d_irq}, 32'h0);
        d_g2_i = d_g2_i ^ 32'h200;
        settle();
        chk("R8 ch2 not enabled", {31'b0, d_irq}, 32'h0);
        wr(9'h128, 32'hFFFF_FFFF);
        chk("R8 ch2 enabled", {31'b0, d_irq}, 32'h1);
        rd(9'h128); chk("R8 only channel bits", rd_d, 32'h3);
        wr(9'h120, 32'hFFFF_FFFF);
        chk("R6 irq cleared", {31'b0, d_irq}, 32'h0);
    endtask

    task automatic t_unmapped();
        wr(9'h010, 32'hFFFF_FFFF);
        wr(9'h124, 32'hFFFF_FFFF);
        wr(9'h002, 32'h0);
        chk("R9 out1 unchanged", d_g1_o, 32'h1234_ABCD);
        chk("R9 oe1 unchanged", d_g1_oe, 32'h0000_FFFF);
        rd(9'h010); chk("R9 read 0x010", rd_d, 32'h0);
        rd(9'h124); chk("R9 read 0x124", rd_d, 32'h0);
        rd(9'h002); chk("R9 misaligned read", rd_d, 32'h0);
        rd(9'h12C); chk("R9 read 0x12C", rd_d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_dir_out();
        t_ch2();
        t_status();
        t_irq();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule